// File: doc/BRIEF.md
# Burst-Mode PCM Serial Word Port

This block is the slave side of a synchronous serial link that carries one speech sample per frame between a codec and a host. The host supplies a burst clock and a single frame-sync line. Both data directions share them: a transmit line driven by the block and a receive line driven by the host. A frame starts at the rising edge of the sync line with no delay. The first data bit belongs to the same clock in which sync is first seen high. The block then moves one word, 8 or 16 bits long, most significant bit first in both directions.

On the parallel side, the host logic writes the next transmit word through a load strobe into a holding register. The block copies that word into its shifter at each frame start, so a word that is not refreshed is sent again. Each received word is presented with a one-clock valid strobe. Frames may follow one another with no idle clock between them. A sync edge that arrives before the current word is finished abandons that word, raises a one-clock error pulse and starts a new frame. Between frames the transmit line is either released, with its output enable low, or kept driven at the last bit sent. A configuration input chooses between the two.

All logic runs on the burst clock. Transmit bits are launched on the rising edge. Receive bits are sampled on the falling edge, in the middle of their bit period.

Top module: `bsp_port`

## Requirements
- R1: `cfg_wide_i` selects the word length, 1 for 16 bits and 0 for 8 bits. The value is captured at the frame-start edge, and a change during a frame does not alter that frame's length.
- R2: A frame starts at the first rising clock edge at which `sync_i` is sampled high after being sampled low. Sync may stay high for 1 up to word length minus 1 clocks, and clocks after the first with sync still high start nothing.
- R3: Transmit bit i of a frame (i = 0 first) appears on `tx_sd_o` just after the rising edge i clocks after the frame-start edge. Bits go most significant first: bits 15 down to 0 of the word in 16-bit mode, so the high byte goes first, and bits 7 down to 0 in 8-bit mode.
- R4: Receive bit i is the value of `rx_sd_i` at the falling edge just before the rising edge i clocks after the frame-start edge. It is taken most significant first, and `rx_word_o` carries the word right-aligned, with bits 15:8 zero in 8-bit mode.
- R5: `rx_valid_o` is high for exactly one clock, starting at the rising edge where the last receive bit is taken (frame-start edge plus word length minus 1), and `rx_word_o` is updated at that same edge.
- R6: A clock with `tx_load_i` high writes `tx_word_i` into the holding register. At frame start the shifter takes the holding register, or `tx_word_i` itself if `tx_load_i` is high at that same edge. Without a new load the previous word is sent again.
- R7: A new frame may start at the edge right after the last transmit bit's clock (frame-start edge plus word length) with no gap, no error and no lost bit.
- R8: A frame-start edge that comes while a word is unfinished, before frame start plus word length, abandons that word without a valid strobe, pulses `frame_err_o` for one clock, and starts the new frame normally.
- R9: During a frame `tx_oe_o` is 1. Between frames `tx_oe_o` equals NOT `cfg_hiz_i`, and `tx_sd_o` holds the last bit sent.
- R10: After reset `tx_sd_o`, `rx_valid_o`, `frame_err_o` and `rx_word_o` are 0, and `tx_oe_o` equals NOT `cfg_hiz_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Burst clock from the host |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wide_i | input | 1 | Word length: 1 selects 16 bits, 0 selects 8 bits |
| cfg_hiz_i | input | 1 | 1 releases the transmit line between frames |
| sync_i | input | 1 | Frame sync; its rising edge starts a frame |
| rx_sd_i | input | 1 | Serial receive data from the host |
| tx_sd_o | output | 1 | Serial transmit data to the host |
| tx_oe_o | output | 1 | Output enable for the transmit pad |
| tx_load_i | input | 1 | Load strobe for the transmit holding register |
| tx_word_i | input | 16 | Next transmit word |
| rx_word_o | output | 16 | Last received word, right-aligned |
| rx_valid_o | output | 1 | One-clock strobe marking a new received word |
| frame_err_o | output | 1 | One-clock pulse when a frame is cut short by sync |

## Verification
The assertions assume that the host keeps sync high for fewer clocks than the word length. Under that assumption every error pulse can be traced to a genuine early restart, never to a held-high sync. The stimulus respects this limit: each sync pulse lasts from one clock up to word length minus 1 clocks. Every input changes just after a rising edge, so the falling-edge receive sample always sees a settled value. The early-restart case is driven as a short pulse after a deliberately truncated word.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic {
    WL_SHORT = 1'b0,
    WL_LONG  = 1'b1
  } wlen_e;
endpackage

// File: rtl/bsp_frame_ctl.sv
module bsp_frame_ctl
  import bsp_pkg::*;
#(
  parameter int unsigned MAX_W   = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic sync_i,
  input  logic wide_i,
  output logic start_o,
  output logic step_o,
  output logic last_o,
  output logic act_o,
  output logic err_o
);
  localparam int unsigned CNT_W = $clog2(MAX_W + 1);
  localparam logic [CNT_W-1:0] LEN_L = CNT_W'(MAX_W);
  localparam logic [CNT_W-1:0] LEN_S = CNT_W'(SHORT_W);

  logic             sync_q, sync_n;
  logic             act_q, act_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  wlen_e            wl_q, wl_n;
  logic             err_q, err_n;

  logic [CNT_W-1:0] len_cur;
  logic             start, at_end, step, last;

  always_comb begin
    len_cur = (wl_q == WL_LONG) ? LEN_L : LEN_S;
    start   = sync_i & ~sync_q;
    at_end  = act_q && (cnt_q == len_cur);
    step    = act_q && !at_end;
    last    = step && (cnt_q == len_cur - 1'b1);
  end

  always_comb begin
    sync_n = sync_i;
    act_n  = act_q;
    cnt_n  = cnt_q;
    wl_n   = wl_q;
    err_n  = 1'b0;
    if (start) begin
      act_n = 1'b1;
      cnt_n = CNT_W'(1);
      wl_n  = wide_i ? WL_LONG : WL_SHORT;
      err_n = act_q && !at_end;
    end else if (step) begin
      cnt_n = cnt_q + 1'b1;
    end else if (at_end) begin
      act_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      wl_q   <= WL_SHORT;
      err_q  <= 1'b0;
    end else begin
      sync_q <= sync_n;
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      wl_q   <= wl_n;
      err_q  <= err_n;
    end
  end

  assign start_o = start;
  assign step_o  = step;
  assign last_o  = last && !start;
  assign act_o   = act_q;
  assign err_o   = err_q;
endmodule

// File: rtl/bsp_tx_shift.sv
module bsp_tx_shift #(
  parameter int unsigned MAX_W   = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             wide_i,
  input  logic             load_i,
  input  logic [MAX_W-1:0] word_i,
  output logic             sd_o
);
  localparam int unsigned PAD_W = MAX_W - SHORT_W;

  logic [MAX_W-1:0] hold_q, hold_n;
  logic [MAX_W-2:0] sh_q, sh_n;
  logic             sd_q, sd_n;
  logic [MAX_W-1:0] word_now, aligned;

  always_comb begin
    word_now = load_i ? word_i : hold_q;
    aligned  = wide_i ? word_now : {word_now[SHORT_W-1:0], {PAD_W{1'b0}}};
    hold_n   = load_i ? word_i : hold_q;
    sh_n     = sh_q;
    sd_n     = sd_q;
    if (start_i) begin
      sd_n = aligned[MAX_W-1];
      sh_n = aligned[MAX_W-2:0];
    end else if (step_i) begin
      sd_n = sh_q[MAX_W-2];
      sh_n = {sh_q[MAX_W-3:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      sd_q   <= 1'b0;
    end else begin
      if (load_i) hold_q <= hold_n;
      if (start_i || step_i) begin
        sh_q <= sh_n;
        sd_q <= sd_n;
      end
    end
  end

  assign sd_o = sd_q;
endmodule

// File: rtl/bsp_rx_shift.sv
module bsp_rx_shift #(
  parameter int unsigned MAX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             sd_i,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             last_i,
  output logic [MAX_W-1:0] word_o,
  output logic             valid_o
);
  logic             smp_q;
  logic [MAX_W-2:0] sh_q, sh_n;
  logic [MAX_W-1:0] word_q, word_n;
  logic             valid_q;

  // Mid-bit sample on the falling edge
  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b0;
    else        smp_q <= sd_i;
  end

  always_comb begin
    sh_n   = sh_q;
    word_n = word_q;
    if (start_i)     sh_n = {{(MAX_W-2){1'b0}}, smp_q};
    else if (step_i) sh_n = {sh_q[MAX_W-3:0], smp_q};
    if (last_i)      word_n = {sh_q, smp_q};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (start_i || step_i) sh_q <= sh_n;
      if (last_i) word_q <= word_n;
      valid_q <= last_i;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/bsp_port.sv
module bsp_port #(
  parameter int unsigned MAX_W   = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             cfg_wide_i,
  input  logic             cfg_hiz_i,
  input  logic             sync_i,
  input  logic             rx_sd_i,
  output logic             tx_sd_o,
  output logic             tx_oe_o,
  input  logic             tx_load_i,
  input  logic [MAX_W-1:0] tx_word_i,
  output logic [MAX_W-1:0] rx_word_o,
  output logic             rx_valid_o,
  output logic             frame_err_o
);
  logic [1:0] rst_pipe;
  logic       rst_s;
  logic       start, step, last, act;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe <= 2'b00;
    else          rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  bsp_frame_ctl #(.MAX_W(MAX_W), .SHORT_W(SHORT_W)) u_ctl (
    .clk_i   (clk_i),
    .rst_n   (rst_s),
    .sync_i  (sync_i),
    .wide_i  (cfg_wide_i),
    .start_o (start),
    .step_o  (step),
    .last_o  (last),
    .act_o   (act),
    .err_o   (frame_err_o)
  );

  bsp_tx_shift #(.MAX_W(MAX_W), .SHORT_W(SHORT_W)) u_tx (
    .clk_i   (clk_i),
    .rst_n   (rst_s),
    .start_i (start),
    .step_i  (step),
    .wide_i  (cfg_wide_i),
    .load_i  (tx_load_i),
    .word_i  (tx_word_i),
    .sd_o    (tx_sd_o)
  );

  bsp_rx_shift #(.MAX_W(MAX_W)) u_rx (
    .clk_i   (clk_i),
    .rst_n   (rst_s),
    .sd_i    (rx_sd_i),
    .start_i (start),
    .step_i  (step),
    .last_i  (last),
    .word_o  (rx_word_o),
    .valid_o (rx_valid_o)
  );

  assign tx_oe_o = act | ~cfg_hiz_i;
endmodule

// File: rtl/bsp_port_chk.sv
module bsp_port_chk (
  input logic clk_i,
  input logic rst_n,
  input logic sync_i,
  input logic start,
  input logic act,
  input logic tx_sd,
  input logic tx_oe,
  input logic cfg_hiz,
  input logic rx_valid,
  input logic frame_err
);
  AST_RXV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5
  AST_RXV_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_n)
    rx_valid |-> $past(act)); // R5
  AST_ERR_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_n)
    frame_err |-> !rx_valid); // R8
  AST_ERR_ON_SYNC: assert property (@(posedge clk_i) disable iff (!rst_n)
    frame_err |-> $past(sync_i)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!act && !start) |=> $stable(tx_sd)); // R9
  AST_DRIVE_MODE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cfg_hiz |-> tx_oe); // R9
endmodule

bind bsp_port bsp_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_s),
  .sync_i    (sync_i),
  .start     (start),
  .act       (act),
  .tx_sd     (tx_sd_o),
  .tx_oe     (tx_oe_o),
  .cfg_hiz   (cfg_hiz_i),
  .rx_valid  (rx_valid_o),
  .frame_err (frame_err_o)
);

// File: tb/bsp_port_tb.sv
module bsp_port_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b1, cfg_hiz = 1'b1;
  logic        sync = 1'b0, rx_sd = 1'b0;
  logic        tx_load = 1'b0;
  logic [15:0] tx_word = '0;
  logic        tx_sd, tx_oe, rx_valid, frame_err;
  logic [15:0] rx_word;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bsp_port u_dut (
    .clk_i(clk), .rst_n_i(rst_n), .cfg_wide_i(cfg_wide), .cfg_hiz_i(cfg_hiz),
    .sync_i(sync), .rx_sd_i(rx_sd), .tx_sd_o(tx_sd), .tx_oe_o(tx_oe),
    .tx_load_i(tx_load), .tx_word_i(tx_word), .rx_word_o(rx_word),
    .rx_valid_o(rx_valid), .frame_err_o(frame_err)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic set_tx(input logic [15:0] w);
    tx_load = 1'b1; tx_word = w;
    @(posedge clk); #1;
    tx_load = 1'b0;
  endtask

  // One full frame; starts and ends just after a rising edge.
  task automatic run_frame(input bit wide, input logic [15:0] txw, input logic [15:0] rxw,
                           input int slen, input bit exp_err, input bit flip,
                           input int ld_at, input logic [15:0] nw);
    int w = wide ? 16 : 8;
    cfg_wide = wide;
    for (int i = 0; i < w; i++) begin
      sync  = (i < slen);
      rx_sd = rxw[w-1-i];
      if (flip && i == 3) cfg_wide = !wide;
      if (i == ld_at) begin tx_load = 1'b1; tx_word = nw; end
      else tx_load = 1'b0;
      @(posedge clk); #1;
      chk("R3 tx bit order", tx_sd, txw[w-1-i]);
      chk("R9 oe in frame", tx_oe, 1'b1);
      chk("R8 error pulse", frame_err, (i == 0) ? exp_err : 1'b0);
      if (i < w-1) chk("R5 no early valid", rx_valid, 1'b0);
    end
    tx_load = 1'b0;
    sync = 1'b0;
    chk("R5 valid at last bit", rx_valid, 1'b1);
    chk("R4 rx word", rx_word, wide ? rxw : {8'h00, rxw[7:0]});
    cfg_wide = wide;
  endtask

  task automatic idle_chk(input logic last_bit);
    @(posedge clk); #1;
    chk("R5 valid one clock", rx_valid, 1'b0);
    chk("R9 idle oe", tx_oe, !cfg_hiz);
    chk("R9 idle hold", tx_sd, last_bit);
    @(posedge clk); #1;
    chk("R9 idle hold later", tx_sd, last_bit);
  endtask

  task automatic t_reset();
    cfg_hiz = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 tx_sd", tx_sd, 1'b0);
    chk("R10 oe", tx_oe, 1'b0);
    chk("R10 valid", rx_valid, 1'b0);
    chk("R10 err", frame_err, 1'b0);
    chk("R10 rx word", rx_word, 16'h0000);
  endtask

  task automatic t_wide();  // R3 R4 high byte first
    set_tx(16'hA53C);
    run_frame(1, 16'hA53C, 16'h5AC3, 1, 0, 0, -1, 16'h0);
    idle_chk(1'b0);
  endtask

  task automatic t_short_long_sync();  // R2 R1 8-bit, sync held W-1
    cfg_hiz = 1'b0;
    set_tx(16'h7E69);
    run_frame(0, 16'h7E69, 16'hFFB4, 7, 0, 0, -1, 16'h0);
    idle_chk(1'b1);
  endtask

  task automatic t_repeat();  // R6 word sent again without load
    run_frame(1, 16'h7E69, 16'h0F31, 2, 0, 0, -1, 16'h0);
    idle_chk(1'b1);
  endtask

  task automatic t_same_edge_load();  // R6 load at frame start edge
    cfg_hiz = 1'b1;
    run_frame(1, 16'h3C96, 16'h8001, 1, 0, 0, 0, 16'h3C96);
    idle_chk(1'b0);
  endtask

  task automatic t_back_to_back();  // R7
    set_tx(16'h1234);
    run_frame(1, 16'h1234, 16'hBEEF, 3, 0, 0, 2, 16'hCAFE);
    run_frame(1, 16'hCAFE, 16'h7001, 2, 0, 0, -1, 16'h0);
    run_frame(0, 16'hCAFE, 16'h00A7, 1, 0, 0, -1, 16'h0);
    idle_chk(1'b0);
  endtask

  task automatic t_width_latch();  // R1 mid-frame width change ignored
    run_frame(1, 16'hCAFE, 16'h6D2B, 1, 0, 1, -1, 16'h0);
    idle_chk(1'b0);
    run_frame(0, 16'hCAFE, 16'h0055, 1, 0, 1, -1, 16'h0);
    idle_chk(1'b0);
  endtask

  task automatic t_abort();  // R8
    set_tx(16'h0F0F);
    cfg_wide = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sync = (i == 0);
      rx_sd = 1'b1;
      @(posedge clk); #1;
      chk("R8 partial no valid", rx_valid, 1'b0);
      chk("R8 partial no err", frame_err, 1'b0);
    end
    run_frame(1, 16'h0F0F, 16'h1248, 1, 1, 0, -1, 16'h0);
    idle_chk(1'b1);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired R0 got=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wide();
    t_short_long_sync();
    t_repeat();
    t_same_edge_load();
    t_back_to_back();
    t_width_latch();
    t_abort();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule